// File: doc/BRIEF.md
# Descriptor-Driven DMA Loop Sequencer

This block is one DMA channel that runs from a transfer control descriptor of eight 32-bit words. The descriptor names a source and a destination address, a signed per-beat step for each, a beat size code for each side, a minor byte count, a current and a begin major iteration count, two end-of-transfer adjustments and a set of control flags. Each service of the channel moves one minor loop. Every beat is a read from the source, then a write of the same data to the destination, on a simple request/acknowledge memory port.

A service starts when software writes the control word with its start bit set, or when the hardware request line is high while the request enable is set. When the major count runs out, the block either applies the end adjustments and reloads the count, or it fetches a new descriptor from memory through the same port. It raises done, a one-cycle interrupt pulse and a configuration-error flag. The descriptor words are written through a small indexed write port. Writes are taken only while the channel is idle.

Top module: `dma_loop_seq`

## Requirements
- R1: After reset, `mem_req`, `busy`, `done`, `irq`, `cfg_err` and `req_en` are all low.
- R2: A size code gives a beat of 2^code bytes: 0 is 1, 1 is 2, 2 is 4, 4 is 16 and 5 is 32 bytes. The code goes out on `mem_size`. Source size sits in word 7 bits [2:0] and destination size in word 7 bits [6:4]. A minor loop ends on the beat where the source bytes moved reach the minor byte count in word 3.
- R3: After each beat, the source address (word 0) and destination address (word 1) each advance by their own sign-extended 16-bit step. The source step is word 2 bits [15:0] and the destination step is word 2 bits [31:16]. A step of 0 keeps the address fixed.
- R4: A service starts on a write of word 7 with bit 8 (start) set, or on `hw_req` while `req_en` is high. It moves one minor loop and then decrements the current count, held in word 6 bits [14:0]. The begin count is in word 6 bits [30:16].
- R5: When the current count reaches zero with scatter/gather off, `done` goes high. The source address is then adjusted by word 4 and the destination address by word 5, both signed 32-bit. The current count reloads from the begin count. `done` clears at the next valid service start.
- R6: When the current count reaches zero, `irq` pulses for one cycle if word 7 bit 9 is set. With word 7 bit 10 set, `irq` also pulses at the end of a service that leaves the current count non-zero and equal to the begin count shifted right by one.
- R7: `req_en` is set by a pulse on `req_en_set`. It is cleared when the major loop completes if word 7 bit 11 is set. While `req_en` is low, `hw_req` starts nothing.
- R8: When the major loop completes with word 7 bit 12 set, the block reads eight words (size code 2) from the address in word 5, stepping by 4. It loads them as words 0 to 7. If the loaded start bit is set, the new transfer runs.
- R9: A start with a zero minor byte count, a current count that is zero or above the begin count, a size code of 3, 6 or 7, or a non-zero reserved bit sets `cfg_err` and issues no beat. The reserved bits are word 6 bits 15 and 31, and word 7 bits 3, 7 and [31:13]. A later valid start clears `cfg_err`.
- R10: A request holds its address, direction and size until `mem_ack`. The write data of each beat equals the read data of the beat before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor word write strobe (taken when idle) |
| cfg_idx | input | 3 | Descriptor word index |
| cfg_wdata | input | 32 | Descriptor word data |
| hw_req | input | 1 | Hardware service request |
| req_en_set | input | 1 | Sets the request enable |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | AW | Beat byte address |
| mem_size | output | 3 | Beat size code |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Beat accepted; read data valid |
| mem_rdata | input | DW | Read data |
| busy | output | 1 | A service or descriptor fetch is in progress |
| done | output | 1 | Major loop complete |
| irq | output | 1 | One-cycle interrupt pulse |
| cfg_err | output | 1 | Last start rejected by the configuration check |
| req_en | output | 1 | Hardware request enable |

## Verification
The assertions assume that the memory side asserts `mem_ack` only while `mem_req` is high. They also assume that descriptor writes arrive only while the channel is idle, so no write races a start. The bench acknowledges beats on an irregular stall pattern, which exercises the hold rule. It writes descriptors only after the channel has been quiet for several cycles. It changes `req_en_set` and `hw_req` only between services.

// File: rtl/dma_loop_pkg.sv
`timescale 1ns/1ps
package dma_loop_pkg;
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FETCH} seq_state_t;

  function automatic logic [31:0] beat_bytes(input logic [2:0] code);
    return 32'd1 << code;
  endfunction

  function automatic logic size_ok(input logic [2:0] code);
    return (code != 3'd3) && (code <= 3'd5);
  endfunction
endpackage

// File: rtl/dma_addr_step.sv
`timescale 1ns/1ps
module dma_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [15:0]   step,
  input  logic [AW-1:0] adj,
  input  logic          use_adj,
  output logic [AW-1:0] nxt
);
  localparam int EXT = AW - 16;
  logic [AW-1:0] step_x;
  assign step_x = {{EXT{step[15]}}, step};
  assign nxt = base + step_x + (use_adj ? adj : '0);
endmodule

// File: rtl/dma_cfg_check.sv
`timescale 1ns/1ps
module dma_cfg_check
  import dma_loop_pkg::*;
#(
  parameter int CW = 15
) (
  input  logic [31:0]   nbytes,
  input  logic [CW-1:0] citer,
  input  logic [CW-1:0] biter,
  input  logic [2:0]    ssize,
  input  logic [2:0]    dsize,
  input  logic          rsv_bad,
  output logic          bad
);
  assign bad = (nbytes == 32'd0) || (citer == '0) || (citer > biter) ||
               !size_ok(ssize) || !size_ok(dsize) || rsv_bad;
endmodule

// File: rtl/dma_loop_seq.sv
`timescale 1ns/1ps
module dma_loop_seq
  import dma_loop_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_idx,
  input  logic [31:0]   cfg_wdata,
  input  logic          hw_req,
  input  logic          req_en_set,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [2:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output logic          cfg_err,
  output logic          req_en
);
  localparam int LAST_WORD = 7;

  seq_state_t state;
  logic [AW-1:0] saddr, daddr, slast, dlast;
  logic [15:0]   soff, doff;
  logic [31:0]   nbytes, bytes_left;
  logic [CW-1:0] citer, biter;
  logic [2:0]    ssize, dsize, fidx;
  logic f_start, f_imaj, f_ihalf, f_dreq, f_sg, rsv6, rsv7;

  logic [31:0]   sbytes;
  logic          last_beat, last_iter, half_hit, use_adj, launch, bad;
  logic [CW-1:0] ncit;
  logic [AW-1:0] s_nxt, d_nxt;
  logic          ld_en;
  logic [2:0]    ld_idx;
  logic [31:0]   ld_data;

  assign sbytes    = beat_bytes(ssize);
  assign last_beat = (bytes_left <= sbytes);
  assign last_iter = (citer == CW'(1));
  assign ncit      = citer - CW'(1);
  assign half_hit  = (ncit == (biter >> 1)) && (ncit != '0);
  assign use_adj   = last_beat && last_iter && !f_sg;
  assign launch    = f_start || (hw_req && req_en);

  dma_addr_step #(.AW(AW)) u_sstep (
    .base(saddr), .step(soff), .adj(slast), .use_adj(use_adj), .nxt(s_nxt));
  dma_addr_step #(.AW(AW)) u_dstep (
    .base(daddr), .step(doff), .adj(dlast), .use_adj(use_adj), .nxt(d_nxt));
  dma_cfg_check #(.CW(CW)) u_check (
    .nbytes(nbytes), .citer(citer), .biter(biter), .ssize(ssize),
    .dsize(dsize), .rsv_bad(rsv6 | rsv7), .bad(bad));

  // Descriptor word source: fetched beats win over the software port.
  always_comb begin
    ld_en   = 1'b0;
    ld_idx  = cfg_idx;
    ld_data = cfg_wdata;
    if (state == S_FETCH && mem_ack) begin
      ld_en   = 1'b1;
      ld_idx  = fidx;
      ld_data = mem_rdata[31:0];
    end else if (state == S_IDLE && cfg_we) begin
      ld_en = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      saddr <= '0; daddr <= '0; slast <= '0; dlast <= '0;
      soff <= '0; doff <= '0; nbytes <= '0; bytes_left <= '0;
      citer <= '0; biter <= '0; ssize <= '0; dsize <= '0; fidx <= '0;
      f_start <= 1'b0; f_imaj <= 1'b0; f_ihalf <= 1'b0; f_dreq <= 1'b0;
      f_sg <= 1'b0; rsv6 <= 1'b0; rsv7 <= 1'b0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_size <= '0;
      mem_wdata <= '0; busy <= 1'b0; done <= 1'b0; irq <= 1'b0;
      cfg_err <= 1'b0; req_en <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (req_en_set) req_en <= 1'b1;
      case (state)
        S_IDLE: begin
          if (launch) begin
            f_start <= 1'b0;
            if (bad) begin
              cfg_err <= 1'b1;
            end else begin
              cfg_err    <= 1'b0;
              done       <= 1'b0;
              busy       <= 1'b1;
              bytes_left <= nbytes;
              mem_req    <= 1'b1;
              mem_we     <= 1'b0;
              mem_addr   <= saddr;
              mem_size   <= ssize;
              state      <= S_RD;
            end
          end
        end
        S_RD: begin
          if (mem_ack) begin
            mem_we    <= 1'b1;
            mem_addr  <= daddr;
            mem_size  <= dsize;
            mem_wdata <= mem_rdata;
            state     <= S_WR;
          end
        end
        S_WR: begin
          if (mem_ack) begin
            saddr <= s_nxt;
            daddr <= d_nxt;
            if (!last_beat) begin
              bytes_left <= bytes_left - sbytes;
              mem_we     <= 1'b0;
              mem_addr   <= s_nxt;
              mem_size   <= ssize;
              state      <= S_RD;
            end else if (last_iter) begin
              done <= 1'b1;
              irq  <= f_imaj;
              if (f_dreq) req_en <= 1'b0;
              if (f_sg) begin
                fidx     <= '0;
                mem_we   <= 1'b0;
                mem_addr <= dlast;
                mem_size <= 3'd2;
                state    <= S_FETCH;
              end else begin
                citer   <= biter;
                mem_req <= 1'b0;
                busy    <= 1'b0;
                state   <= S_IDLE;
              end
            end else begin
              citer   <= ncit;
              irq     <= f_ihalf && half_hit;
              mem_req <= 1'b0;
              busy    <= 1'b0;
              state   <= S_IDLE;
            end
          end
        end
        S_FETCH: begin
          if (mem_ack) begin
            mem_addr <= mem_addr + AW'(32'd4);
            fidx     <= fidx + 3'd1;
            if (fidx == 3'(LAST_WORD)) begin
              mem_req <= 1'b0;
              busy    <= 1'b0;
              state   <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase

      if (ld_en) begin
        case (ld_idx)
          3'd0: saddr  <= ld_data[AW-1:0];
          3'd1: daddr  <= ld_data[AW-1:0];
          3'd2: begin soff <= ld_data[15:0]; doff <= ld_data[31:16]; end
          3'd3: nbytes <= ld_data;
          3'd4: slast  <= ld_data[AW-1:0];
          3'd5: dlast  <= ld_data[AW-1:0];
          3'd6: begin
            citer <= ld_data[CW-1:0];
            biter <= ld_data[16+CW-1:16];
            rsv6  <= |{ld_data[31:16+CW], ld_data[15:CW]};
          end
          default: begin
            ssize   <= ld_data[2:0];
            dsize   <= ld_data[6:4];
            f_start <= ld_data[8];
            f_imaj  <= ld_data[9];
            f_ihalf <= ld_data[10];
            f_dreq  <= ld_data[11];
            f_sg    <= ld_data[12];
            rsv7    <= |{ld_data[31:13], ld_data[7], ld_data[3]};
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_loop_seq_chk.sv
`timescale 1ns/1ps
module dma_loop_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [2:0]    mem_size,
  input logic          busy,
  input logic          done,
  input logic          irq,
  input logic          cfg_err,
  input logic          req_en
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size));

  assert_size_legal_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_size != 3'd3) && (mem_size <= 3'd5));

  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !mem_req);

  assert_req_busy_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_irq_after_write_R6: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mem_req && mem_we && mem_ack));

  assert_done_after_write_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(mem_req && mem_we && mem_ack));

  assert_reqen_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(req_en) |-> $past(mem_req && mem_we && mem_ack));
endmodule

bind dma_loop_seq dma_loop_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_size(mem_size), .busy(busy), .done(done),
  .irq(irq), .cfg_err(cfg_err), .req_en(req_en));

// File: tb/sim_dma_loop_seq.sv
`timescale 1ns/1ps
module sim_dma_loop_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        hw_req = 1'b0;
  logic        req_en_set = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [2:0]  mem_size;
  logic        busy, done, irq, cfg_err, req_en;

  int n_chk = 0, n_fail = 0, beat_cnt = 0, irq_cnt = 0, cyc = 0, stall = 0;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [2:0]  size;
    logic [31:0] data;
  } beat_t;
  beat_t expq[$];
  logic [31:0] desc_mem [16];

  always #4 clk = ~clk;

  dma_loop_seq u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .hw_req(hw_req), .req_en_set(req_en_set), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .irq(irq), .cfg_err(cfg_err),
    .req_en(req_en));

  function automatic logic [31:0] model(input logic [31:0] a);
    if (a >= 32'h1000 && a < 32'h1040) return desc_mem[a[5:2]];
    return {a[15:0] ^ 16'hBEEF, a[15:0]};
  endfunction

  always_comb mem_rdata = model(mem_addr);

  // Memory responder and scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
    end else begin
      stall++;
      mem_ack = mem_req && (stall % 3 != 1);
      if (irq) irq_cnt++;
      if (mem_req && mem_ack) begin
        beat_t e;
        beat_cnt++;
        n_chk++;
        if (expq.size() == 0) begin
          n_fail++;
          $display("FAIL R4 unexpected beat: actual we=%0b addr=%h size=%0d, expected none",
                   mem_we, mem_addr, mem_size);
        end else begin
          e = expq.pop_front();
          if (e.we !== mem_we || e.addr !== mem_addr || e.size !== mem_size ||
              (e.we && e.data !== mem_wdata)) begin
            n_fail++;
            $display("FAIL R2 R3 R10 beat: actual we=%0b addr=%h size=%0d data=%h, expected we=%0b addr=%h size=%0d data=%h",
                     mem_we, mem_addr, mem_size, mem_wdata, e.we, e.addr, e.size, e.data);
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all R): actual cycle=%0d, expected finish earlier", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_desc(input logic [31:0] s, d, offs, nb, sl, dl, cnt, flg);
    wr_word(3'd0, s);  wr_word(3'd1, d);  wr_word(3'd2, offs); wr_word(3'd3, nb);
    wr_word(3'd4, sl); wr_word(3'd5, dl); wr_word(3'd6, cnt);  wr_word(3'd7, flg);
  endtask

  // Driver: pushes the expected beats of one minor loop
  task automatic push_copy(input logic [31:0] s, d, input int soff, doff,
                           input logic [2:0] sc, dc, input int nb);
    int left = nb;
    logic [31:0] sa = s;
    logic [31:0] da = d;
    while (left > 0) begin
      expq.push_back({1'b0, sa, sc, 32'h0});
      expq.push_back({1'b1, da, dc, model(sa)});
      sa = sa + soff;
      da = da + doff;
      left = left - (1 << sc);
    end
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 5) begin
      @(negedge clk);
      if (!busy && !mem_req) quiet++;
      else quiet = 0;
    end
  endtask

  initial begin
    int b0, i0;
    for (int k = 0; k < 16; k++) desc_mem[k] = 32'h0;
    // chained descriptor at 0x1000: 2-byte beats, 4 bytes, start + major irq
    desc_mem[0] = 32'h4000; desc_mem[1] = 32'h5000; desc_mem[2] = {16'd2, 16'd2};
    desc_mem[3] = 32'd4;    desc_mem[4] = 32'h0;    desc_mem[5] = 32'h0;
    desc_mem[6] = 32'h0001_0001; desc_mem[7] = 32'h311;

    repeat (5) @(negedge clk);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    chk("R1 busy/done/irq", {29'b0, busy, done, irq}, 32'd0);
    chk("R1 cfg_err/req_en", {30'b0, cfg_err, req_en}, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // T1: 4-byte beats, adjust -12 both sides, major irq (R2 R3 R5 R6)
    push_copy(32'h100, 32'h200, 4, 4, 3'd2, 3'd2, 12);
    load_desc(32'h100, 32'h200, {16'd4, 16'd4}, 32'd12, 32'hFFFF_FFF4,
              32'hFFFF_FFF4, 32'h0001_0001, 32'h322);
    wait_idle();
    chk("R5 done after major", {31'b0, done}, 32'd1);
    chk("R6 major irq count", irq_cnt, 32'd1);
    chk("R2 T1 queue drained", expq.size(), 32'd0);
    // relaunch: adjusted addresses return to start, count reloaded (R5)
    push_copy(32'h100, 32'h200, 4, 4, 3'd2, 3'd2, 12);
    wr_word(3'd7, 32'h322);
    wait_idle();
    chk("R5 relaunch queue drained", expq.size(), 32'd0);
    chk("R6 second irq", irq_cnt, 32'd2);

    // T2: source step 0 holds address, 1-byte beats, no irq flag (R3 R6)
    push_copy(32'h300, 32'h400, 0, 1, 3'd0, 3'd0, 3);
    load_desc(32'h300, 32'h400, {16'd1, 16'd0}, 32'd3, 32'h0, 32'h0, 32'h0001_0001, 32'h100);
    wait_idle();
    chk("R3 fixed-source queue drained", expq.size(), 32'd0);
    chk("R6 no irq without flag", irq_cnt, 32'd2);

    // T3: 32-byte beats, then 16-byte beats with negative destination step (R2 R3)
    push_copy(32'h800, 32'hA00, 32, 32, 3'd5, 3'd5, 64);
    load_desc(32'h800, 32'hA00, {16'd32, 16'd32}, 32'd64, 32'h0, 32'h0, 32'h0001_0001, 32'h155);
    wait_idle();
    chk("R2 32-byte queue drained", expq.size(), 32'd0);
    push_copy(32'h900, 32'hB00, 16, -16, 3'd4, 3'd4, 32);
    load_desc(32'h900, 32'hB00, {16'hFFF0, 16'd16}, 32'd32, 32'h0, 32'h0, 32'h0001_0001, 32'h144);
    wait_idle();
    chk("R3 negative step queue drained", expq.size(), 32'd0);

    // T4: hardware requests, 4 major iterations, half irq, disable-request (R4 R6 R7)
    load_desc(32'h2000, 32'h3000, {16'd4, 16'd4}, 32'd4, 32'h0, 32'h0, 32'h0004_0004, 32'hE22);
    b0 = beat_cnt; i0 = irq_cnt;
    hw_req = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7 no service while req_en low", beat_cnt - b0, 32'd0);
    push_copy(32'h2000, 32'h3000, 4, 4, 3'd2, 3'd2, 16);
    @(negedge clk); req_en_set = 1'b1;
    @(negedge clk); req_en_set = 1'b0;
    wait_idle();
    chk("R4 four services drained", expq.size(), 32'd0);
    chk("R4 beat count", beat_cnt - b0, 32'd8);
    chk("R6 half + major irq", irq_cnt - i0, 32'd2);
    chk("R7 req_en cleared", {31'b0, req_en}, 32'd0);
    b0 = beat_cnt;
    repeat (10) @(negedge clk);
    chk("R7 no service after clear", beat_cnt - b0, 32'd0);
    hw_req = 1'b0;

    // T5: configuration errors (R9)
    b0 = beat_cnt;
    load_desc(32'h100, 32'h200, {16'd4, 16'd4}, 32'd0, 32'h0, 32'h0, 32'h0001_0001, 32'h122);
    wait_idle();
    chk("R9 zero byte count", {31'b0, cfg_err}, 32'd1);
    load_desc(32'h100, 32'h200, {16'd4, 16'd4}, 32'd4, 32'h0, 32'h0, 32'h0002_0003, 32'h122);
    wait_idle();
    chk("R9 current above begin", {31'b0, cfg_err}, 32'd1);
    load_desc(32'h100, 32'h200, {16'd4, 16'd4}, 32'd4, 32'h0, 32'h0, 32'h0001_0001, 32'h123);
    wait_idle();
    chk("R9 size code 3", {31'b0, cfg_err}, 32'd1);
    load_desc(32'h100, 32'h200, {16'd4, 16'd4}, 32'd4, 32'h0, 32'h0, 32'h0001_0001, 32'h2122);
    wait_idle();
    chk("R9 reserved bit", {31'b0, cfg_err}, 32'd1);
    chk("R9 no beats on error", beat_cnt - b0, 32'd0);

    // T6: scatter/gather chain to descriptor at 0x1000 (R8)
    i0 = irq_cnt;
    push_copy(32'h600, 32'h700, 4, 4, 3'd2, 3'd2, 4);
    for (int k = 0; k < 8; k++) expq.push_back({1'b0, 32'h1000 + 32'(4 * k), 3'd2, 32'h0});
    push_copy(32'h4000, 32'h5000, 2, 2, 3'd1, 3'd1, 4);
    load_desc(32'h600, 32'h700, {16'd4, 16'd4}, 32'd4, 32'h0, 32'h1000, 32'h0001_0001, 32'h1322);
    wait_idle();
    chk("R8 chain queue drained", expq.size(), 32'd0);
    chk("R8 irq per descriptor", irq_cnt - i0, 32'd2);
    chk("R9 cfg_err cleared by valid start", {31'b0, cfg_err}, 32'd0);
    chk("R5 done after chain", {31'b0, done}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule